// File: doc/BRIEF.md
# Encoder Input Glitch Filter

This block cleans the three signals of an incremental encoder (phase A, phase B and the index mark) before they reach a quadrature decoder. Each raw input first crosses into the system clock domain through a two-stage synchroniser. A per-channel state machine then decides when the clean output may follow the synchronised level. A new level is accepted only after it has been sampled unchanged for a programmable window of `max_count + 2` consecutive clock cycles. With the 10 ns system clock, a window lasts `(max_count + 2) * 10` ns.

The window comes from a 32-bit filter configuration word. Only its low 21 bits form `max_count`; the bits above are ignored. A separate enable input selects filtering or bypass. In bypass, each output simply re-registers its synchronised input. Software changes the configuration only while the surrounding peripheral is disabled, so the block treats the configuration as static while it qualifies a level.

Each channel's state machine has two states:
- `ST_SETTLED`: the output matches the synchronised input and the counter is zero.
- `ST_QUALIFY`: a differing level is being timed.

Transitions:
- *mismatch-seen* (`ST_SETTLED` to `ST_QUALIFY`): the synchronised input differs from the output. The counter loads 1.
- *glitch-dropped* (`ST_QUALIFY` to `ST_SETTLED`): the input returns to the output level. The counter clears and the output is unchanged.
- *level-accepted* (`ST_QUALIFY` to `ST_SETTLED`): the count reaches the window length. The output takes the new level.
- *hold* (`ST_QUALIFY` to `ST_QUALIFY`): the counter increments.
- *bypass* (any state to `ST_SETTLED`): the enable input is low.

Top module: `enc_glitch_filter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, all three filtered outputs are low, even if the raw inputs are high.
- R2: With `filt_en` low, each output follows its raw input three clock edges after the raw change, and a raw pulse of a single cycle still appears on the output.
- R3: With `filt_en` high, a raw level held for `max_count + 2` consecutive cycles reaches the output on the `max_count + 4`-th clock edge after the raw change.
- R4: With `filt_en` high, a raw pulse shorter than `max_count + 2` cycles never changes the output.
- R5: A return of the synchronised input to the output level, even for one cycle, restarts the window. The output then changes only `max_count + 2` cycles after the last restart.
- R6: Bits 31 to 21 of `flt_cfg` have no effect; only bits 20 to 0 give `max_count`.
- R7: The channels are independent. Channel 0 is phase A, channel 1 is phase B and channel 2 is index. Activity on one channel never changes another channel's output.
- R8: High-to-low transitions are filtered with the same window as low-to-high ones. An accepted pulse of L cycles therefore appears on the output for L cycles.
- R9: With `max_count` equal to 0, the window is two cycles: a one-cycle pulse is rejected and a two-cycle pulse passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10 ns period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | 1 = filter, 0 = bypass after synchroniser |
| flt_cfg | input | 32 | Filter configuration word; bits 20:0 are max_count |
| enc_raw | input | 3 | Raw inputs: bit 0 phase A, bit 1 phase B, bit 2 index |
| enc_clean | output | 3 | Filtered outputs, same bit order |

## Verification
The filter is driven with single pulses whose lengths sit one cycle below, exactly at and above the window, for several window sizes including the two-cycle minimum. This separates an off-by-one in the window from a correct count. The measured rise and fall edges confirm both the latency and that falling edges are qualified too. A pulse broken by a one-cycle dropout tells a restarting counter from one that only pauses. Configuration words with the upper bits set, and stimulus on one channel at a time, show that the upper bits and the other channels have no influence.

// File: rtl/enc_filt_pkg.sv
package enc_filt_pkg;
    localparam int unsigned NUM_CH   = 3;
    localparam int unsigned CFG_W    = 32;
    localparam int unsigned MAXC_W   = 21;
    localparam int unsigned SYNC_STG = 2;

    typedef enum logic {
        ST_SETTLED = 1'b0,
        ST_QUALIFY = 1'b1
    } flt_state_e;
endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/enc_chan_filter.sv
module enc_chan_filter
    import enc_filt_pkg::*;
#(
    parameter int unsigned CW = MAXC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          filt_en,
    input  logic [CW-1:0] max_count,
    input  logic          sync_in,
    output logic          filt_out
);
    localparam int unsigned CNT_W = CW + 1;

    flt_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx, win;
    logic             out_nx;

    assign win = {1'b0, max_count} + CNT_W'(2);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        out_nx   = filt_out;
        if (!filt_en) begin
            state_nx = ST_SETTLED;
            cnt_nx   = '0;
            out_nx   = sync_in;
        end else begin
            unique case (state)
                ST_SETTLED: begin
                    if (sync_in != filt_out) begin
                        state_nx = ST_QUALIFY;
                        cnt_nx   = CNT_W'(1);
                    end
                end
                ST_QUALIFY: begin
                    if (sync_in == filt_out) begin
                        state_nx = ST_SETTLED;
                        cnt_nx   = '0;
                    end else if (cnt + CNT_W'(1) == win) begin
                        state_nx = ST_SETTLED;
                        cnt_nx   = '0;
                        out_nx   = sync_in;
                    end else begin
                        cnt_nx   = cnt + CNT_W'(1);
                    end
                end
                default: begin
                    state_nx = ST_SETTLED;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SETTLED;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_out <= 1'b0;
        else        filt_out <= out_nx;
    end

    AST_CHANGE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && filt_en && $past(filt_en) && filt_out != $past(filt_out))
        |-> $past(state) == ST_QUALIFY); // R4

    AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(filt_en)) |-> filt_out == $past(sync_in)); // R2

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en |-> cnt < win); // R3

    AST_DROPOUT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUALIFY && sync_in == filt_out) |=> state == ST_SETTLED); // R5
endmodule

// File: rtl/enc_glitch_filter.sv
module enc_glitch_filter
    import enc_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic [CFG_W-1:0]  flt_cfg,
    input  logic [NUM_CH-1:0] enc_raw,
    output logic [NUM_CH-1:0] enc_clean
);
    logic [MAXC_W-1:0] max_count;
    logic [NUM_CH-1:0] synced;

    assign max_count = flt_cfg[MAXC_W-1:0];

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            enc_sync #(.STAGES(SYNC_STG)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .d_async (enc_raw[ch]),
                .q_sync  (synced[ch])
            );
            enc_chan_filter #(.CW(MAXC_W)) u_filt (
                .clk       (clk),
                .rst_n     (rst_n),
                .filt_en   (filt_en),
                .max_count (max_count),
                .sync_in   (synced[ch]),
                .filt_out  (enc_clean[ch])
            );
        end
    endgenerate

    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> enc_clean == '0); // R1
endmodule

// File: tb/tb_enc_glitch_filter.sv
module tb_enc_glitch_filter;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        filt_en = 1'b0;
    logic [31:0] flt_cfg = '0;
    logic [2:0]  enc_raw = '0;
    logic [2:0]  enc_clean;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    enc_glitch_filter dut (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en),
        .flt_cfg(flt_cfg), .enc_raw(enc_raw), .enc_clean(enc_clean)
    );

    typedef struct packed {
        logic        en;
        logic [31:0] cfg;
        logic [7:0]  len;
        logic [1:0]  ch;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 32'd3,         8'd1, 2'd0},  // R2 bypass, single-cycle pulse
        '{1'b0, 32'd0,         8'd4, 2'd1},  // R2
        '{1'b1, 32'd0,         8'd1, 2'd0},  // R9 reject
        '{1'b1, 32'd0,         8'd2, 2'd0},  // R9 pass
        '{1'b1, 32'd2,         8'd3, 2'd1},  // R4 one short
        '{1'b1, 32'd2,         8'd4, 2'd1},  // R3 exact
        '{1'b1, 32'd2,         8'd9, 2'd2},  // R3/R8 longer
        '{1'b1, 32'd5,         8'd6, 2'd2},  // R4
        '{1'b1, 32'd5,         8'd7, 2'd0},  // R3
        '{1'b1, 32'hFFE0_0002, 8'd3, 2'd1},  // R6 reject
        '{1'b1, 32'hFFE0_0002, 8'd4, 2'd1},  // R6 pass
        '{1'b1, 32'h8020_0001, 8'd3, 2'd2}   // R6 W=3 pass
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    // pattern bit k = raw level after k posedges; returns first rise and first fall after it
    task automatic run_pattern(input int ch, input logic [63:0] pat,
                               output int rise, output int fall, output bit others_ok);
        rise = 0; fall = 0; others_ok = 1'b1;
        @(negedge clk);
        enc_raw[ch] = pat[0];
        for (int k = 1; k < 64; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (rise == 0 && enc_clean[ch]) rise = k;
            else if (rise != 0 && fall == 0 && !enc_clean[ch]) fall = k;
            for (int o = 0; o < 3; o++)
                if (o != ch && enc_clean[o]) others_ok = 1'b0;
            enc_raw[ch] = pat[k];
        end
        enc_raw = '0;
        settle(4);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int rise, fall, w, exp_rise, exp_fall;
        bit others;
        logic [63:0] pat;

        // R1: reset with raw inputs high
        enc_raw = 3'b111;
        settle(4);
        check(enc_clean == 3'b000, "R1 in reset", enc_clean, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(enc_clean == 3'b000, "R1 after release", enc_clean, 0);
        enc_raw = 3'b000;
        settle(6);

        // table walk
        for (int v = 0; v < NV; v++) begin
            filt_en = VECS[v].en;
            flt_cfg = VECS[v].cfg;
            settle(2);
            w   = int'(VECS[v].cfg[20:0]) + 2;
            pat = (64'd1 << VECS[v].len) - 64'd1;
            run_pattern(int'(VECS[v].ch), pat, rise, fall, others);
            if (!VECS[v].en) begin
                exp_rise = 3;
                exp_fall = int'(VECS[v].len) + 3;
            end else if (int'(VECS[v].len) >= w) begin
                exp_rise = w + 2;
                exp_fall = int'(VECS[v].len) + w + 2;
            end else begin
                exp_rise = 0;
                exp_fall = 0;
            end
            check(rise == exp_rise, $sformatf("R3/R4/R6/R9 rise v%0d", v), rise, exp_rise);
            check(fall == exp_fall, $sformatf("R8/R2 fall v%0d", v), fall, exp_fall);
            check(others, $sformatf("R7 isolation v%0d", v), others, 1);
        end

        // R5: window 4, high 3 cycles, low 1, high 6 -> restart at cycle 4
        filt_en = 1'b1;
        flt_cfg = 32'd2;
        settle(2);
        pat = 64'b11_1111_0111;
        run_pattern(0, pat, rise, fall, others);
        check(rise == 10, "R5 restart after dropout", rise, 10);

        // R8: falling glitch on a held-high output is rejected
        @(negedge clk);
        enc_raw[1] = 1'b1;
        settle(12);
        check(enc_clean[1] == 1'b1, "R8 high accepted", enc_clean[1], 1);
        enc_raw[1] = 1'b0;
        settle(3);
        enc_raw[1] = 1'b1;
        settle(12);
        check(enc_clean[1] == 1'b1, "R8 low glitch rejected", enc_clean[1], 1);
        enc_raw = '0;
        settle(12);
        check(enc_clean == 3'b000, "R8 low accepted", enc_clean, 0);

        // R1: reset in the middle of qualification
        enc_raw[2] = 1'b1;
        settle(4);
        rst_n = 1'b0;
        enc_raw = '0;
        settle(2);
        rst_n = 1'b1;
        settle(10);
        check(enc_clean == 3'b000, "R1 mid-qualify reset", enc_clean, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule